// File: doc/BRIEF.md
# Move-ALU Pair Fusing Decoder

This decode-stage block looks at a four-byte window of register-form integer instructions. If the window starts with a 32-bit register copy and is followed by a two-operand ALU instruction that overwrites the copy's destination, the block replaces the pair with a single non-destructive micro-op of the form `dst = src1 op src2`. The instruction bytes stay as they are. Only the decoding changes, and executing the two instructions one after the other gives the same architectural result.

When the pair does not qualify, the block decodes only the first instruction of the window and reports a 2-byte consumption. The upstream fetch logic then advances the window by the reported length. Results leave through a register that has one cycle of latency and a valid/ready handshake. While the downstream side holds the output, the input is stalled.

Top module: `mov_alu_fuser`

## Requirements
- R1: After reset, `uop_valid_o` is 0 and `win_ready_o` is 1.
- R2: Window bytes 8B C3 03 C1 (byte 0 in `win_i[7:0]`) produce one fused micro-op with class ADD (1), dst 0, src1 3, src2 1, flag write 1, fused 1 and length 4.
- R3: The class field encodes the operation. MOV is 0. ALU opcode 03 gives ADD = 1, 2B gives SUB = 2, 23 gives AND = 3, 0B gives OR = 4 and 33 gives XOR = 5. An unknown instruction gives BAD = 7. Each of the five ALU opcodes fuses with a preceding 8B under the same conditions.
- R4: Fusion needs byte 0 = 8B, byte 2 to be an ALU opcode, and both ModRM bytes (bytes 1 and 3) to be in register form (bits 7:6 = 11). It also needs the reg fields (bits 5:3) of both ModRM bytes to be equal. If any of these fails, only the first instruction is emitted, with length 2.
- R5: If the ALU instruction's r/m register (byte 3, bits 2:0) equals the copy's destination, the pair is not fused.
- R6: An unfused copy 8B gives class MOV, dst = reg, src1 = src2 = r/m, flag write 0 and length 2.
- R7: An unfused ALU instruction gives dst = reg, src1 = reg, src2 = r/m, flag write 1 and length 2.
- R8: A fused micro-op's flag write equals that of the ALU instruction alone, which is 1.
- R9: An instruction that is not recognised, or that is not in register form, gives class BAD, flag write 0, fused 0 and length 2.
- R10: An accepted window appears at the output one cycle later. While `uop_valid_o` is 1 and `uop_ready_i` is 0, the output holds steady and `win_ready_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| win_i | input | 32 | Instruction window, byte 0 in bits 7:0 |
| win_valid_i | input | 1 | Window holds at least four valid bytes |
| win_ready_o | output | 1 | Window accepted on this edge when valid |
| uop_valid_o | output | 1 | Micro-op output valid |
| uop_ready_i | input | 1 | Downstream accepts micro-op |
| uop_cls_o | output | 3 | Operation class |
| uop_dst_o | output | 3 | Destination register |
| uop_src1_o | output | 3 | First source register |
| uop_src2_o | output | 3 | Second source register |
| uop_wflags_o | output | 1 | Micro-op writes flags |
| uop_fused_o | output | 1 | Micro-op came from a fused pair |
| uop_len_o | output | 3 | Bytes consumed (2 or 4) |

## Verification
The assertions assume that `win_i` is held steady while the upstream side waits for acceptance, and that every window carries four meaningful bytes. The stimulus meets both assumptions: a window changes only after the edge that accepted it, and it always fills all four bytes. Random windows favour the copy opcode, the ALU opcodes, register-form ModRM bytes and matching reg fields, so the fusion conditions are reached often. Directed cases cover the exact boundary of each condition, plus a stall in which the output is held.

// File: rtl/fuse_pkg.sv
package fuse_pkg;
  localparam int REG_W = 3;
  localparam int LEN_W = 3;

  localparam logic [7:0] OPC_MOV = 8'h8B;
  localparam logic [7:0] OPC_ADD = 8'h03;
  localparam logic [7:0] OPC_SUB = 8'h2B;
  localparam logic [7:0] OPC_AND = 8'h23;
  localparam logic [7:0] OPC_OR  = 8'h0B;
  localparam logic [7:0] OPC_XOR = 8'h33;

  typedef enum logic [2:0] {
    CLS_MOV = 3'd0,
    CLS_ADD = 3'd1,
    CLS_SUB = 3'd2,
    CLS_AND = 3'd3,
    CLS_OR  = 3'd4,
    CLS_XOR = 3'd5,
    CLS_BAD = 3'd7
  } uop_cls_e;

  typedef struct packed {
    logic             is_mov;
    logic             is_alu;
    logic             reg_form;
    uop_cls_e         cls;
    logic [REG_W-1:0] rf;
    logic [REG_W-1:0] rm;
  } insn_t;

  typedef struct packed {
    uop_cls_e         cls;
    logic [REG_W-1:0] dst;
    logic [REG_W-1:0] src1;
    logic [REG_W-1:0] src2;
    logic             wflags;
    logic             fused;
    logic [LEN_W-1:0] len;
  } uop_t;
endpackage

// File: rtl/insn_classify.sv
module insn_classify
  import fuse_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic [BYTE_W-1:0] opc_i,
  input  logic [BYTE_W-1:0] modrm_i,
  output insn_t             insn_o
);
  always_comb begin
    insn_o          = '0;
    insn_o.cls      = CLS_BAD;
    insn_o.reg_form = (modrm_i[7:6] == 2'b11);
    insn_o.rf       = modrm_i[5:3];
    insn_o.rm       = modrm_i[2:0];
    unique case (opc_i)
      OPC_MOV: begin insn_o.is_mov = 1'b1; insn_o.cls = CLS_MOV; end
      OPC_ADD: begin insn_o.is_alu = 1'b1; insn_o.cls = CLS_ADD; end
      OPC_SUB: begin insn_o.is_alu = 1'b1; insn_o.cls = CLS_SUB; end
      OPC_AND: begin insn_o.is_alu = 1'b1; insn_o.cls = CLS_AND; end
      OPC_OR:  begin insn_o.is_alu = 1'b1; insn_o.cls = CLS_OR;  end
      OPC_XOR: begin insn_o.is_alu = 1'b1; insn_o.cls = CLS_XOR; end
      default: ;
    endcase
  end
endmodule

// File: rtl/fuse_detect.sv
module fuse_detect
  import fuse_pkg::*;
(
  input  insn_t first_i,
  input  insn_t second_i,
  output uop_t  uop_o
);
  logic first_ok, can_fuse;

  assign first_ok = (first_i.is_mov | first_i.is_alu) & first_i.reg_form;
  // second src must not alias the copy's destination
  assign can_fuse = first_i.is_mov & first_i.reg_form &
                    second_i.is_alu & second_i.reg_form &
                    (first_i.rf == second_i.rf) &
                    (second_i.rm != first_i.rf);

  always_comb begin
    uop_o     = '0;
    uop_o.cls = CLS_BAD;
    uop_o.len = LEN_W'(2);
    if (can_fuse) begin
      uop_o.cls    = second_i.cls;
      uop_o.dst    = first_i.rf;
      uop_o.src1   = first_i.rm;
      uop_o.src2   = second_i.rm;
      uop_o.wflags = 1'b1;
      uop_o.fused  = 1'b1;
      uop_o.len    = LEN_W'(4);
    end else if (first_ok) begin
      uop_o.cls    = first_i.cls;
      uop_o.dst    = first_i.rf;
      uop_o.src1   = first_i.is_mov ? first_i.rm : first_i.rf;
      uop_o.src2   = first_i.rm;
      uop_o.wflags = first_i.is_alu;
    end
  end
endmodule

// File: rtl/uop_reg.sv
module uop_reg #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         in_valid_i,
  output logic         in_ready_o,
  input  logic [W-1:0] in_data_i,
  output logic         out_valid_o,
  input  logic         out_ready_i,
  output logic [W-1:0] out_data_o
);
  assign in_ready_o = ~out_valid_o | out_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      out_data_o  <= '0;
    end else if (in_ready_o) begin
      out_valid_o <= in_valid_i;
      if (in_valid_i) out_data_o <= in_data_i;
    end
  end
endmodule

// File: rtl/mov_alu_fuser.sv
module mov_alu_fuser
  import fuse_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [4*BYTE_W-1:0]   win_i,
  input  logic                  win_valid_i,
  output logic                  win_ready_o,
  output logic                  uop_valid_o,
  input  logic                  uop_ready_i,
  output logic [2:0]            uop_cls_o,
  output logic [REG_W-1:0]      uop_dst_o,
  output logic [REG_W-1:0]      uop_src1_o,
  output logic [REG_W-1:0]      uop_src2_o,
  output logic                  uop_wflags_o,
  output logic                  uop_fused_o,
  output logic [LEN_W-1:0]      uop_len_o
);
  localparam int N_SLOT = 2;
  localparam int UOP_W  = $bits(uop_t);

  insn_t insn [N_SLOT];
  uop_t  uop_d, uop_q;

  for (genvar s = 0; s < N_SLOT; s++) begin : g_slot
    insn_classify #(.BYTE_W(BYTE_W)) u_cls (
      .opc_i  (win_i[(2*s)*BYTE_W +: BYTE_W]),
      .modrm_i(win_i[(2*s+1)*BYTE_W +: BYTE_W]),
      .insn_o (insn[s])
    );
  end

  fuse_detect u_det (
    .first_i (insn[0]),
    .second_i(insn[1]),
    .uop_o   (uop_d)
  );

  uop_reg #(.W(UOP_W)) u_reg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .in_valid_i (win_valid_i),
    .in_ready_o (win_ready_o),
    .in_data_i  (uop_d),
    .out_valid_o(uop_valid_o),
    .out_ready_i(uop_ready_i),
    .out_data_o (uop_q)
  );

  assign uop_cls_o    = uop_q.cls;
  assign uop_dst_o    = uop_q.dst;
  assign uop_src1_o   = uop_q.src1;
  assign uop_src2_o   = uop_q.src2;
  assign uop_wflags_o = uop_q.wflags;
  assign uop_fused_o  = uop_q.fused;
  assign uop_len_o    = uop_q.len;
endmodule

// File: rtl/fuser_chk.sv
module fuser_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        win_valid_i,
  input logic        win_ready_o,
  input logic        uop_valid_o,
  input logic        uop_ready_i,
  input logic [2:0]  uop_cls_o,
  input logic [2:0]  uop_dst_o,
  input logic [2:0]  uop_src2_o,
  input logic        uop_wflags_o,
  input logic        uop_fused_o,
  input logic [2:0]  uop_len_o
);
  // R10
  hold_on_stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (uop_valid_o && !uop_ready_i) |=> (uop_valid_o && $stable({uop_cls_o, uop_dst_o, uop_src2_o, uop_len_o})));
  // R10
  accept_latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (win_valid_i && win_ready_o) |=> uop_valid_o);
  // R4
  fused_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uop_valid_o |-> (uop_fused_o ? (uop_len_o == 3'd4) : (uop_len_o == 3'd2)));
  // R5
  no_alias_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (uop_valid_o && uop_fused_o) |-> (uop_src2_o != uop_dst_o));
  // R8
  fused_flags_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (uop_valid_o && uop_fused_o) |-> (uop_wflags_o && uop_cls_o >= 3'd1 && uop_cls_o <= 3'd5));
  // R9
  bad_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (uop_valid_o && uop_cls_o == 3'd7) |-> (!uop_wflags_o && !uop_fused_o));
endmodule

bind mov_alu_fuser fuser_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .win_valid_i (win_valid_i),
  .win_ready_o (win_ready_o),
  .uop_valid_o (uop_valid_o),
  .uop_ready_i (uop_ready_i),
  .uop_cls_o   (uop_cls_o),
  .uop_dst_o   (uop_dst_o),
  .uop_src2_o  (uop_src2_o),
  .uop_wflags_o(uop_wflags_o),
  .uop_fused_o (uop_fused_o),
  .uop_len_o   (uop_len_o)
);

// File: tb/mov_alu_fuser_test.sv
module mov_alu_fuser_test;
  localparam time CLK_PERIOD = 10ns;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] win_i = '0;
  logic        win_valid_i = 1'b0;
  logic        win_ready_o;
  logic        uop_valid_o;
  logic        uop_ready_i = 1'b1;
  logic [2:0]  uop_cls_o, uop_dst_o, uop_src1_o, uop_src2_o, uop_len_o;
  logic        uop_wflags_o, uop_fused_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  mov_alu_fuser uut (.*);

  // expected {cls,dst,src1,src2,wflags,fused,len}
  function automatic logic [16:0] ref_uop(logic [31:0] w);
    logic [7:0] o0, m0, o1, m1;
    logic [2:0] c0, c1;
    logic a0, a1, r0, r1;
    o0 = w[7:0]; m0 = w[15:8]; o1 = w[23:16]; m1 = w[31:24];
    c0 = 3'd7; c1 = 3'd7;
    case (o0) 8'h8B: c0 = 0; 8'h03: c0 = 1; 8'h2B: c0 = 2; 8'h23: c0 = 3; 8'h0B: c0 = 4; 8'h33: c0 = 5; default: ; endcase
    case (o1) 8'h03: c1 = 1; 8'h2B: c1 = 2; 8'h23: c1 = 3; 8'h0B: c1 = 4; 8'h33: c1 = 5; default: ; endcase
    a0 = (c0 != 3'd7); a1 = (c1 != 3'd7);
    r0 = (m0[7:6] == 2'b11); r1 = (m1[7:6] == 2'b11);
    if (c0 == 0 && r0 && a1 && r1 && m0[5:3] == m1[5:3] && m1[2:0] != m0[5:3])
      return {c1, m0[5:3], m0[2:0], m1[2:0], 1'b1, 1'b1, 3'd4};
    if (a0 && r0 && c0 == 0)
      return {3'd0, m0[5:3], m0[2:0], m0[2:0], 1'b0, 1'b0, 3'd2};
    if (a0 && r0)
      return {c0, m0[5:3], m0[5:3], m0[2:0], 1'b1, 1'b0, 3'd2};
    return {3'd7, 3'd0, 3'd0, 3'd0, 1'b0, 1'b0, 3'd2};
  endfunction

  function automatic logic [16:0] dut_uop();
    return {uop_cls_o, uop_dst_o, uop_src1_o, uop_src2_o, uop_wflags_o, uop_fused_o, uop_len_o};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // drive window, accepted on next edge (ready asserted), check at following negedge
  task automatic send_chk(string req, logic [31:0] w);
    @(negedge clk_i);
    win_i = w; win_valid_i = 1'b1;
    @(negedge clk_i);
    win_valid_i = 1'b0;
    chk(req, {14'd0, uop_valid_o, dut_uop()}, {14'd0, 1'b1, ref_uop(w)});
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [16:0] hold;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk_i);
    // R1
    chk("R1 valid", {31'd0, uop_valid_o}, 32'd0);
    chk("R1 ready", {31'd0, win_ready_o}, 32'd1);
    rst_ni = 1'b1;

    // R2: 8B C3 03 C1
    send_chk("R2", 32'hC1_03_C3_8B);
    chk("R2 exact", {15'd0, dut_uop()}, {15'd0, 3'd1, 3'd0, 3'd3, 3'd1, 1'b1, 1'b1, 3'd4});
    // R3: each ALU opcode fused, mov ecx<-edx ; op ecx, ebx  (mod11 reg1 rm2 = CA; reg1 rm3 = CB)
    send_chk("R3 sub", 32'hCB_2B_CA_8B);
    chk("R3 sub cls", {29'd0, uop_cls_o}, 32'd2);
    send_chk("R3 and", 32'hCB_23_CA_8B);
    chk("R3 and cls", {29'd0, uop_cls_o}, 32'd3);
    send_chk("R3 or",  32'hCB_0B_CA_8B);
    chk("R3 or cls", {29'd0, uop_cls_o}, 32'd4);
    send_chk("R3 xor", 32'hCB_33_CA_8B);
    chk("R3 xor cls", {29'd0, uop_cls_o}, 32'd5);
    // R4: reg mismatch (D9: reg3 rm1)
    send_chk("R4 regmis", 32'hD9_03_C3_8B);
    chk("R4 len", {29'd0, uop_len_o}, 32'd2);
    // R4: memory form second modrm
    send_chk("R4 mod", 32'h01_03_C3_8B);
    // R4: second not ALU
    send_chk("R4 opc", 32'hC1_8B_C3_8B);
    // R5: alias (C0: reg0 rm0)
    send_chk("R5 alias", 32'hC0_03_C3_8B);
    chk("R5 fused", {31'd0, uop_fused_o}, 32'd0);
    // R6: lone mov
    send_chk("R6 mov", 32'h00_90_D1_8B);
    chk("R6 src", {26'd0, uop_src1_o, uop_src2_o}, {26'd0, 3'd1, 3'd1});
    // R7: lone ALU sub edx, esi (D6)
    send_chk("R7 alu", 32'h00_90_D6_2B);
    chk("R7 flds", {23'd0, uop_dst_o, uop_src1_o, uop_src2_o}, {23'd0, 3'd2, 3'd2, 3'd6});
    // R8
    chk("R8 flags", {31'd0, uop_wflags_o}, 32'd1);
    // R9: unknown opcode and non-register move
    send_chk("R9 unk", 32'hC1_03_C3_90);
    chk("R9 cls", {29'd0, uop_cls_o}, 32'd7);
    send_chk("R9 memmov", 32'hC1_03_43_8B);

    // R10: stall holds output and blocks input
    @(negedge clk_i);
    uop_ready_i = 1'b0;
    win_i = 32'hC1_03_C3_8B; win_valid_i = 1'b1;
    @(negedge clk_i);
    hold = dut_uop();
    win_i = 32'hCB_33_CA_8B;
    repeat (3) begin
      @(negedge clk_i);
      chk("R10 hold", {15'd0, dut_uop()}, {15'd0, ref_uop(32'hC1_03_C3_8B)});
      chk("R10 ready", {31'd0, win_ready_o}, 32'd0);
    end
    uop_ready_i = 1'b1;
    @(negedge clk_i);
    win_valid_i = 1'b0;
    chk("R10 next", {15'd0, dut_uop()}, {15'd0, ref_uop(32'hCB_33_CA_8B)});
    @(negedge clk_i);
    chk("R10 drain", {31'd0, uop_valid_o}, 32'd0);

    // random mix
    for (int i = 0; i < 400; i++) begin
      logic [7:0] b0, b1, b2, b3;
      logic [7:0] ops [6];
      ops = '{8'h8B, 8'h03, 8'h2B, 8'h23, 8'h0B, 8'h33};
      b0 = ($urandom_range(9) < 6) ? ops[$urandom_range(1) == 0 ? 0 : $urandom_range(5)] : 8'($urandom);
      b1 = 8'($urandom);
      if ($urandom_range(4) != 0) b1[7:6] = 2'b11;
      b2 = ($urandom_range(4) != 0) ? ops[$urandom_range(5)] : 8'($urandom);
      b3 = 8'($urandom);
      if ($urandom_range(4) != 0) b3[7:6] = 2'b11;
      if ($urandom_range(2) != 0) b3[5:3] = b1[5:3];
      send_chk("R3/R4/R5 random", {b3, b2, b1, b0});
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule